// File: doc/BRIEF.md
# Periodic Tick Timer with Missed-Period Counter

This block is a 32-bit up-counting tick timer for a processor subsystem. It runs from the system clock. A programmable prescaler turns that clock into a count enable, nominally 1 MHz. The main counter advances by one on each enabled tick and is compared against a programmable compare value. When the next count equals the compare value, a match event occurs. On a match the counter can either return to zero, for a periodic tick, or run on towards its 2^32 wrap.

Every match sets a latched interrupt pending flag and steps a 4-bit overflow counter. After a late interrupt service, software reads the overflow counter to learn how many periods passed. It then clears that counter with a self-clearing command bit. The interrupt request output is driven only while the pending flag and the enable bit are both set. A 3-bit level code accompanies the request.

Software reaches the block through a word-addressed register port: a write strobe with write data, and a combinational read data bus.

The interrupt controller is a three-state machine:

| State | Meaning |
|---|---|
| IRQ_IDLE | Nothing is pending. |
| IRQ_HELD | A match is pending and the enable bit is off. |
| IRQ_FIRING | A match is pending, the enable bit is on, and the request is driven. |

Its transitions are:

| Transition | Trigger |
|---|---|
| match | Moves from any state to HELD or FIRING, depending on the enable. |
| clear | Moves from HELD or FIRING to IDLE when no match arrives in the same cycle. |
| enable-on | Moves from HELD to FIRING. |
| enable-off | Moves from FIRING to HELD. |

Register map (word address, 3 bits):

| Address | Register | Fields |
|---|---|---|
| 0 | control | run bit 8, restart-on-match bit 9, overflow-clear bit 10, overflow count bits 15:12 |
| 1 | compare | 32-bit compare value |
| 2 | counter | 32-bit count |
| 3 | interrupt enable | enable bit 25 |
| 4 | interrupt status | reads pending at bit 25; writing 1 to bit 25 clears it |
| 5 | level | level bits 6:4 |
| 6 | prescaler | 8-bit prescaler value |
| 7 | unused | reads 0 |

Top module: `tick_timer`

## Requirements
- R1: The prescaler register (address 6, bits 7:0, reset value 0xE7) gives one count tick every 256 − P system clocks. A write restarts its phase, so the first tick comes 256 − P clocks after the write edge. The register reads back the written value.
- R2: The counter (address 2) advances by exactly one per tick while control bit 8 (run) is 1. While run is 0 it holds its value.
- R3: With control bit 9 (restart) set, a tick that would bring the count to the compare value (address 1) is a match and loads 0 instead. The period is therefore the compare value in ticks.
- R4: With restart clear, the count takes the compare value and keeps counting, wrapping from 0xFFFFFFFF to 0. Reaching the compare value is still a match.
- R5: Control bits 15:12 hold a 4-bit overflow count that steps by one on each match and wraps from 15 to 0.
- R6: Writing 1 to control bit 10 zeroes the overflow count, and this wins over a match in the same cycle. Bit 10 always reads 0.
- R7: A write to the counter register loads the written value and overrides a tick in the same cycle. That tick does not count as a match.
- R8: Every match sets the pending flag, read at bit 25 of address 4, whatever the enable bit is. Writing 1 to bit 25 of address 4 clears the flag, but a match in the same cycle keeps it set.
- R9: irq_o is 1 exactly while pending is 1 and the enable bit (address 3, bit 25) is 1. Changing the enable bit takes effect on the edge of the write.
- R10: The level register (address 5, bits 6:4) drives irq_level_o and reads back. Bit 7 reads 0.
- R11: After reset, control, compare, counter, enable, status and level read 0, the prescaler reads 0xE7, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Interrupt level code |

## Verification
The counting path is exercised with random compare values and random run lengths in restart mode. These runs separate correct modulo counting from off-by-one period errors, and correct 4-bit wrapping of the overflow count from saturation. Directed runs cover the following:
- running without restart, which shows the count passing the compare value and wrapping at 2^32;
- exactly 16 and 17 matches, which expose the overflow-count wrap;
- a compare value of 1 with clear commands issued while running, which decides the clear-versus-match priority for both the overflow count and the pending flag;
- the reset prescaler value with a phase-restarting write, which pins the tick spacing to 25 clocks.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_CMP   = 3'd1,
        A_COUNT = 3'd2,
        A_IEN   = 3'd3,
        A_ISTAT = 3'd4,
        A_LEVEL = 3'd5,
        A_PRESC = 3'd6
    } reg_addr_e;

    localparam int BIT_RUN     = 8;
    localparam int BIT_RESTART = 9;
    localparam int BIT_OVFCLR  = 10;
    localparam int OVF_LSB     = 12;
    localparam int BIT_IRQ     = 25;
    localparam int LEVEL_LSB   = 4;

    typedef enum logic [1:0] {
        IRQ_IDLE   = 2'd0,
        IRQ_HELD   = 2'd1,
        IRQ_FIRING = 2'd2
    } irq_state_e;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int PSC_W = 8,
    parameter logic [PSC_W-1:0] RESET_VAL = 8'hE7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PSC_W-1:0] load_val_i,
    output logic [PSC_W-1:0] reload_o,
    output logic             tick_o
);
    logic [PSC_W-1:0] div_q;

    assign tick_o = (div_q == {PSC_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_o <= RESET_VAL;
            div_q    <= RESET_VAL;
        end else if (load_i) begin
            reload_o <= load_val_i;
            div_q    <= load_val_i;
        end else if (tick_o) begin
            div_q <= reload_o;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R1: after a tick the divider restarts from the programmed value
    p_reload_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o && !load_i |=> div_q == reload_o);

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
    parameter int CNT_W = 32,
    parameter int OVF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic [OVF_W-1:0] ovf_o,
    output logic             match_o
);
    logic [CNT_W-1:0] next_cnt;
    logic             step;

    assign step     = tick_i && run_i && !cnt_wr_i;
    assign next_cnt = count_o + 1'b1;
    assign match_o  = step && (next_cnt == cmp_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (cnt_wr_i) begin
            count_o <= cnt_wdata_i;
        end else if (match_o && restart_i) begin
            count_o <= '0;
        end else if (step) begin
            count_o <= next_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_o <= '0;
        end else if (ovf_clr_i) begin
            ovf_o <= '0;
        end else if (match_o) begin
            ovf_o <= ovf_o + 1'b1;
        end
    end

    // R2: a stopped counter holds unless written
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && !cnt_wr_i |=> $stable(count_o));
    // R3: restart mode returns to zero on a match
    p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match_o && restart_i |=> count_o == '0);
    // R5: overflow count steps by one per match
    p_ovf_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_o && !ovf_clr_i |=> ovf_o == OVF_W'($past(ovf_o) + 1'b1));
    // R6: clear wins over a match
    p_ovf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr_i |=> ovf_o == '0);

endmodule

// File: rtl/tt_irq.sv
module tt_irq
    import tick_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_i,
    input  logic en_wr_i,
    input  logic en_wdata_i,
    input  logic clr_i,
    output logic en_o,
    output logic pending_o,
    output logic irq_o
);
    irq_state_e state_q, state_d;
    logic       en_d;

    assign en_d = en_wr_i ? en_wdata_i : en_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (match_i) state_d = en_d ? IRQ_FIRING : IRQ_HELD;
            end
            IRQ_HELD, IRQ_FIRING: begin
                if (match_i || !clr_i) state_d = en_d ? IRQ_FIRING : IRQ_HELD;
                else                   state_d = IRQ_IDLE;
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            en_o    <= 1'b0;
        end else begin
            state_q <= state_d;
            en_o    <= en_d;
        end
    end

    always_comb begin
        pending_o = (state_q != IRQ_IDLE);
        irq_o     = (state_q == IRQ_FIRING);
    end

    // R8: every match leaves the flag pending
    p_match_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> pending_o);
    // R8: clear without a match empties the flag
    p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !match_i |=> !pending_o);
    // R9: request only with the enable set
    p_irq_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en_o);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int OVF_W = 4,
    parameter int PSC_W = 8,
    parameter int LVL_W = 3,
    parameter logic [PSC_W-1:0] PSC_RESET = 8'hE7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq_o,
    output logic [LVL_W-1:0] irq_level_o
);
    localparam int LEVEL_MSB = LEVEL_LSB + LVL_W - 1;
    localparam int OVF_MSB   = OVF_LSB + OVF_W - 1;

    logic             wr_ctrl, wr_cmp, wr_count, wr_ien, wr_istat, wr_level, wr_presc;
    logic             run_q, restart_q;
    logic [CNT_W-1:0] cmp_q, count;
    logic [OVF_W-1:0] ovf;
    logic [PSC_W-1:0] presc;
    logic             tick, match, irq_en, pending;

    always_comb begin
        wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
        wr_cmp   = reg_wr && (reg_addr == A_CMP);
        wr_count = reg_wr && (reg_addr == A_COUNT);
        wr_ien   = reg_wr && (reg_addr == A_IEN);
        wr_istat = reg_wr && (reg_addr == A_ISTAT);
        wr_level = reg_wr && (reg_addr == A_LEVEL);
        wr_presc = reg_wr && (reg_addr == A_PRESC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            restart_q   <= 1'b0;
            cmp_q       <= '0;
            irq_level_o <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q     <= reg_wdata[BIT_RUN];
                restart_q <= reg_wdata[BIT_RESTART];
            end
            if (wr_cmp)   cmp_q       <= reg_wdata;
            if (wr_level) irq_level_o <= reg_wdata[LEVEL_MSB:LEVEL_LSB];
        end
    end

    tt_prescaler #(.PSC_W(PSC_W), .RESET_VAL(PSC_RESET)) i_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_presc),
        .load_val_i (reg_wdata[PSC_W-1:0]),
        .reload_o   (presc),
        .tick_o     (tick)
    );

    tt_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) i_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .run_i       (run_q),
        .restart_i   (restart_q),
        .cmp_i       (cmp_q),
        .cnt_wr_i    (wr_count),
        .cnt_wdata_i (reg_wdata),
        .ovf_clr_i   (wr_ctrl && reg_wdata[BIT_OVFCLR]),
        .count_o     (count),
        .ovf_o       (ovf),
        .match_o     (match)
    );

    tt_irq i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_i    (match),
        .en_wr_i    (wr_ien),
        .en_wdata_i (reg_wdata[BIT_IRQ]),
        .clr_i      (wr_istat && reg_wdata[BIT_IRQ]),
        .en_o       (irq_en),
        .pending_o  (pending),
        .irq_o      (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[BIT_RUN]         = run_q;
                reg_rdata[BIT_RESTART]     = restart_q;
                reg_rdata[OVF_MSB:OVF_LSB] = ovf;
            end
            A_CMP:   reg_rdata = cmp_q;
            A_COUNT: reg_rdata = count;
            A_IEN:   reg_rdata[BIT_IRQ] = irq_en;
            A_ISTAT: reg_rdata[BIT_IRQ] = pending;
            A_LEVEL: reg_rdata[LEVEL_MSB:LEVEL_LSB] = irq_level_o;
            A_PRESC: reg_rdata[PSC_W-1:0] = presc;
            default: reg_rdata = '0;
        endcase
    end

    // R9: the request follows pending and enable together
    p_irq_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (pending && irq_en));

endmodule

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    logic [2:0]  irq_level_o;

    int n_total = 0;
    int n_fail = 0;

    localparam logic [2:0] CTRL = 3'd0, CMP = 3'd1, CNT = 3'd2, IEN = 3'd3,
                           STAT = 3'd4, LVL = 3'd5, PSC = 3'd6;
    localparam logic [31:0] RUN = 32'h100, RST = 32'h200, OCLR = 32'h400, IB = 32'h0200_0000;

    always #2.5 clk = ~clk;

    tick_timer i_tick_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .irq_level_o(irq_level_o)
    );

    function automatic logic [31:0] exp_count(input int cmp, input int n);
        return 32'(n % cmp);
    endfunction

    function automatic logic [31:0] exp_ovf(input int cmp, input int n);
        return 32'((n / cmp) % 16);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // run for exactly n ticks (prescaler at 0xFF gives one tick per clock)
    task automatic run_ticks(input logic [31:0] mode, input int n);
        wr(CTRL, mode | RUN);
        repeat (n - 1) @(negedge clk);
        wr(CTRL, mode);
    endtask

    task automatic prep(input logic [31:0] cmp, input logic [31:0] start);
        wr(STAT, IB);
        wr(CTRL, OCLR);
        wr(CMP, cmp);
        wr(CNT, start);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(CTRL, v);  check("R11 ctrl", v, 32'h0);
        rd(CMP, v);   check("R11 cmp", v, 32'h0);
        rd(CNT, v);   check("R11 count", v, 32'h0);
        rd(IEN, v);   check("R11 enable", v, 32'h0);
        rd(STAT, v);  check("R11 status", v, 32'h0);
        rd(LVL, v);   check("R11 level", v, 32'h0);
        rd(PSC, v);   check("R11 prescaler", v, 32'hE7);
        check("R11 irq", {31'b0, irq_o}, 32'h0);

        // R1 prescaler 0xE7: ticks 25 clocks apart
        prep(32'd1000, 32'd0);
        wr(CTRL, RUN | RST);
        wr(PSC, 32'hE7);
        wr(CNT, 32'd0);
        repeat (250) @(negedge clk);
        wr(CTRL, RST);
        rd(CNT, v);   check("R1 ticks in 252 clocks", v, 32'd10);
        wr(PSC, 32'hFF);
        rd(PSC, v);   check("R1 prescaler readback", v, 32'hFF);

        // R3/R5 random runs in restart mode
        for (int it = 0; it < 10; it++) begin
            int c, n;
            c = 1 + int'($urandom % 20);
            n = 1 + int'($urandom % 60);
            prep(32'(c), 32'd0);
            run_ticks(RST, n);
            rd(CNT, v);  check("R3 random count", v, exp_count(c, n));
            rd(CTRL, v); check("R5 random overflow", (v >> 12) & 32'hF, exp_ovf(c, n));
            rd(STAT, v); check("R8 random pending", v, (n >= c) ? IB : 32'h0);
        end

        // R2 stopped counter holds
        rd(CNT, v);
        repeat (7) @(negedge clk);
        rd(CNT, v2); check("R2 hold while stopped", v2, v);

        // R4 no restart: passes compare
        prep(32'd5, 32'd0);
        run_ticks(32'h0, 8);
        rd(CNT, v);  check("R4 count past compare", v, 32'd8);
        rd(CTRL, v); check("R4 match counted", (v >> 12) & 32'hF, 32'd1);

        // R4 wrap at 2^32
        prep(32'd1, 32'hFFFF_FFFE);
        run_ticks(32'h0, 3);
        rd(CNT, v);  check("R4 wrap count", v, 32'd1);
        rd(CTRL, v); check("R4 wrap match", (v >> 12) & 32'hF, 32'd1);

        // R5 16 and 17 matches
        prep(32'd1, 32'd0);
        run_ticks(RST, 16);
        rd(CTRL, v); check("R5 sixteen matches wrap", (v >> 12) & 32'hF, 32'd0);
        rd(STAT, v); check("R5 pending after 16", v, IB);
        prep(32'd1, 32'd0);
        run_ticks(RST, 17);
        rd(CTRL, v); check("R5 seventeen matches", (v >> 12) & 32'hF, 32'd1);

        // R6 clear wins over match (compare 1 matches every tick)
        prep(32'd1, 32'd0);
        wr(CTRL, RUN | RST);
        repeat (3) @(negedge clk);
        wr(CTRL, RUN | RST | OCLR);
        rd(CTRL, v); check("R6 clear beats match", v, RUN | RST);
        // R8 set wins over clear while matching
        wr(STAT, IB);
        rd(STAT, v); check("R8 set beats clear", v, IB);
        // R7 counter write overrides tick
        wr(CMP, 32'd1000);
        wr(CNT, 32'd500);
        rd(CNT, v);  check("R7 counter write", v, 32'd500);
        wr(CTRL, RST);

        // R8/R9 pending independent of enable
        rd(STAT, v); check("R8 pending with enable off", v, IB);
        check("R9 irq masked", {31'b0, irq_o}, 32'h0);
        wr(IEN, IB);
        check("R9 irq on enable", {31'b0, irq_o}, 32'h1);
        wr(STAT, IB);
        check("R9 irq after clear", {31'b0, irq_o}, 32'h0);
        rd(STAT, v); check("R8 cleared", v, 32'h0);
        rd(IEN, v);  check("R9 enable kept", v, IB);

        // R10 level
        wr(LVL, 32'h60);
        check("R10 level 6", {29'b0, irq_level_o}, 32'd6);
        wr(LVL, 32'hF0);
        rd(LVL, v);  check("R10 level readback", v, 32'h70);
        check("R10 level 7", {29'b0, irq_level_o}, 32'd7);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule